// File: doc/BRIEF.md
# Prioritised Event Latch and Service Controller

This block collects up to 32 event lines and turns each rising edge into a latched request. Latched requests are filtered by a per-event enable mask and, for the upper range of event numbers, by a global enable. The block then picks one request to enter service. Entry into service is recorded in a pending register. That register keeps every event that is active or nested, so a handler for a low-ranked event can be interrupted by a higher-ranked one. When a handler finishes, its owner pulses a retire strobe, which releases the innermost active event.

Software can set and clear latched requests only for events it has disabled in the mask. It can change the mask only while a privilege input is high. The mask and pending contents are visible at the ports only while that input is high. The latch register is visible at all times.

Top module: `evt_core_ctrl`

## Requirements
- R1: After reset, the latch, mask and pending registers are all zero and the global enable is off.
- R2: An input that is sampled high after having been sampled low sets its latch bit on the second rising clock edge after the sample. An input that stays high sets the bit only once.
- R3: On the clock edge where an event enters service, its pending bit sets and its latch bit clears.
- R4: While an event's pending bit is set, a new rising edge on the same input is latched and held until that event can be accepted again.
- R5: The pending bit of an enabled event with nothing pending rises on the third clock edge after the input is first sampled high.
- R6: A latched event whose mask bit is 0 stays latched and never becomes pending. A mask bit of 1 allows service.
- R7: A latch write (latWr high) loads latWrData into latch bits whose mask bit is 0. It leaves bits whose mask bit is 1 unchanged. An edge that is detected in the same cycle still sets its bit.
- R8: A cycle with retStb high clears the lowest-numbered set pending bit. No event is accepted in that cycle.
- R9: maskRd and pendRd read as zero while priv is low. A mask write (maskWr) takes effect only while priv is high.
- R10: Among the eligible latched events, the lowest bit index is accepted first. takenVld pulses high with that index on takenIdx in the cycle before its pending bit sets.
- R11: An event is accepted only if its index is lower than the index of every set pending bit. This is how nesting works.
- R12: Events with index GP_FIRST or above are eligible only while the global enable is on. gieSet turns the enable on, and gieClr turns it off. If both are high in the same cycle, gieClr wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | NUM_EVT | Raw event request lines |
| priv | input | 1 | Privileged access qualifier |
| latWr | input | 1 | Latch write strobe |
| latWrData | input | NUM_EVT | Latch write value |
| maskWr | input | 1 | Mask write strobe |
| maskWrData | input | NUM_EVT | Mask write value |
| gieSet | input | 1 | Turn global enable on |
| gieClr | input | 1 | Turn global enable off |
| retStb | input | 1 | Retire the innermost active event |
| latchRd | output | NUM_EVT | Latch register contents |
| maskRd | output | NUM_EVT | Mask contents, zero unless priv |
| pendRd | output | NUM_EVT | Pending contents, zero unless priv |
| gieOn | output | 1 | Global enable state |
| takenVld | output | 1 | An event enters service this cycle |
| takenIdx | output | 6 | Index of the event entering service |

## Verification
The bench builds the block with the defaults NUM_EVT = 32 and GP_FIRST = 5. With these values it can exercise both events that ignore the global enable (indices 0 to 4) and events that are gated by it (index 6 is used), and it uses the full register width for the software writes to the latch. A nesting chain of indices 4, then 1, then 3, mixed with retire strobes, tests the order in which events are accepted. The expected acceptance order is held in a scoreboard queue and compared against takenIdx.

// File: rtl/evt_core_pkg.sv
package evt_core_pkg;
  localparam int IDX_W = 6;

  typedef struct packed {
    logic             acceptEn;
    logic [IDX_W-1:0] acceptIdx;
    logic             retireEn;
    logic [IDX_W-1:0] retireIdx;
  } evtCmd_t;
endpackage

// File: rtl/evt_core_select.sv
module evt_core_select
  import evt_core_pkg::*;
#(
  parameter int NUM_EVT  = 32,
  parameter int GP_FIRST = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] latchIn,
  input  logic [NUM_EVT-1:0] maskIn,
  input  logic [NUM_EVT-1:0] pendIn,
  input  logic               gieIn,
  input  logic               retStb,
  output evtCmd_t            cmd
);
  logic [NUM_EVT-1:0] gateMask;
  logic [NUM_EVT-1:0] eligible;
  logic               eFound, pFound;
  logic [IDX_W-1:0]   eIdx, pIdx;

  generate
    for (genvar g = 0; g < NUM_EVT; g++) begin : gGate
      if (g >= GP_FIRST) begin : gGp
        assign gateMask[g] = gieIn;
      end else begin : gSys
        assign gateMask[g] = 1'b1;
      end
    end
  endgenerate

  assign eligible = latchIn & maskIn & gateMask;

  always_comb begin
    eFound = 1'b0;
    eIdx   = '0;
    pFound = 1'b0;
    pIdx   = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        eFound = 1'b1;
        eIdx   = IDX_W'(i);
      end
      if (pendIn[i]) begin
        pFound = 1'b1;
        pIdx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    cmd           = '0;
    cmd.acceptEn  = eFound && !retStb && (!pFound || (eIdx < pIdx));
    cmd.acceptIdx = eIdx;
    cmd.retireEn  = retStb && pFound;
    cmd.retireIdx = pIdx;
  end

  // R10
  accept_is_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.acceptEn |-> ((latchIn & maskIn & (NUM_EVT'(1) << cmd.acceptIdx)) != '0));

  // R12
  gp_needs_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.acceptEn && (cmd.acceptIdx >= IDX_W'(GP_FIRST))) |-> gieIn);

  // R8
  no_accept_on_ret_chk: assert property (@(posedge clk) disable iff (!rstN)
    retStb |-> !cmd.acceptEn);
endmodule

// File: rtl/evt_core_regs.sv
module evt_core_regs
  import evt_core_pkg::*;
#(
  parameter int NUM_EVT = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               priv,
  input  logic               latWr,
  input  logic [NUM_EVT-1:0] latWrData,
  input  logic               maskWr,
  input  logic [NUM_EVT-1:0] maskWrData,
  input  logic               gieSet,
  input  logic               gieClr,
  input  evtCmd_t            cmd,
  output logic [NUM_EVT-1:0] latchQ,
  output logic [NUM_EVT-1:0] maskQ,
  output logic [NUM_EVT-1:0] pendQ,
  output logic               gieQ
);
  logic [NUM_EVT-1:0] syncQ, prevQ, edgeV;
  logic [NUM_EVT-1:0] acceptOh, retireOh, latchNext, latchSetSrc;

  assign edgeV    = syncQ & ~prevQ;
  assign acceptOh = cmd.acceptEn ? (NUM_EVT'(1) << cmd.acceptIdx) : '0;
  assign retireOh = cmd.retireEn ? (NUM_EVT'(1) << cmd.retireIdx) : '0;
  assign latchSetSrc = edgeV | (latWr ? (latWrData & ~maskQ) : '0);

  always_comb begin
    latchNext = latchQ;
    if (latWr) latchNext = (latchQ & maskQ) | (latWrData & ~maskQ);
    latchNext = (latchNext & ~acceptOh) | edgeV;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= '0;
      prevQ  <= '0;
      latchQ <= '0;
      maskQ  <= '0;
      pendQ  <= '0;
      gieQ   <= 1'b0;
    end else begin
      syncQ  <= evtIn;
      prevQ  <= syncQ;
      latchQ <= latchNext;
      pendQ  <= (pendQ & ~retireOh) | acceptOh;
      if (maskWr && priv) maskQ <= maskWrData;
      if (gieClr)      gieQ <= 1'b0;
      else if (gieSet) gieQ <= 1'b1;
    end
  end

  // R3
  accept_sets_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|acceptOh) |=> ((pendQ & $past(acceptOh)) == $past(acceptOh)));

  // R8
  retire_drops_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.retireEn |=> ($countones(pendQ) == $countones($past(pendQ)) - 1));

  // R9
  mask_priv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskWr && !priv) |=> $stable(maskQ));

  // R2
  latch_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((latchQ & ~$past(latchQ) & ~$past(latchSetSrc)) == '0));
endmodule

// File: rtl/evt_core_ctrl.sv
module evt_core_ctrl
  import evt_core_pkg::*;
#(
  parameter int NUM_EVT  = 32,
  parameter int GP_FIRST = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               priv,
  input  logic               latWr,
  input  logic [NUM_EVT-1:0] latWrData,
  input  logic               maskWr,
  input  logic [NUM_EVT-1:0] maskWrData,
  input  logic               gieSet,
  input  logic               gieClr,
  input  logic               retStb,
  output logic [NUM_EVT-1:0] latchRd,
  output logic [NUM_EVT-1:0] maskRd,
  output logic [NUM_EVT-1:0] pendRd,
  output logic               gieOn,
  output logic               takenVld,
  output logic [IDX_W-1:0]   takenIdx
);
  evtCmd_t            cmd;
  logic [NUM_EVT-1:0] latchQ, maskQ, pendQ;
  logic               gieQ;

  evt_core_regs #(.NUM_EVT(NUM_EVT)) uRegs (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .priv(priv),
    .latWr(latWr), .latWrData(latWrData),
    .maskWr(maskWr), .maskWrData(maskWrData),
    .gieSet(gieSet), .gieClr(gieClr), .cmd(cmd),
    .latchQ(latchQ), .maskQ(maskQ), .pendQ(pendQ), .gieQ(gieQ)
  );

  evt_core_select #(.NUM_EVT(NUM_EVT), .GP_FIRST(GP_FIRST)) uSel (
    .clk(clk), .rstN(rstN), .latchIn(latchQ), .maskIn(maskQ),
    .pendIn(pendQ), .gieIn(gieQ), .retStb(retStb), .cmd(cmd)
  );

  assign latchRd  = latchQ;
  assign maskRd   = priv ? maskQ : '0;
  assign pendRd   = priv ? pendQ : '0;
  assign gieOn    = gieQ;
  assign takenVld = cmd.acceptEn;
  assign takenIdx = cmd.acceptIdx;

  // R11
  nest_outranks_chk: assert property (@(posedge clk) disable iff (!rstN)
    takenVld |-> ((pendQ & ((NUM_EVT'(1) << takenIdx) - NUM_EVT'(1))) == '0)
                 && !pendQ[takenIdx[4:0]]);
endmodule

// File: tb/evt_core_ctrl_test.sv
module evt_core_ctrl_test;
  localparam int N = 32;

  logic         clk = 0;
  logic         rstN = 0;
  logic [N-1:0] evtIn = '0;
  logic         priv = 1;
  logic         latWr = 0;
  logic [N-1:0] latWrData = '0;
  logic         maskWr = 0;
  logic [N-1:0] maskWrData = '0;
  logic         gieSet = 0, gieClr = 0, retStb = 0;
  logic [N-1:0] latchRd, maskRd, pendRd;
  logic         gieOn, takenVld;
  logic [5:0]   takenIdx;

  int nChk = 0, nFail = 0;
  int expQ[$];
  bit finished = 0;

  always #10 clk = ~clk;

  evt_core_ctrl uut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .priv(priv),
    .latWr(latWr), .latWrData(latWrData), .maskWr(maskWr),
    .maskWrData(maskWrData), .gieSet(gieSet), .gieClr(gieClr),
    .retStb(retStb), .latchRd(latchRd), .maskRd(maskRd), .pendRd(pendRd),
    .gieOn(gieOn), .takenVld(takenVld), .takenIdx(takenIdx)
  );

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected acceptances
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rstN && takenVld) begin
        nChk++;
        if (expQ.size() == 0) begin
          nFail++;
          $display("FAIL R10 actual=%0d expected=none", takenIdx);
        end else begin
          int e;
          e = expQ.pop_front();
          if (int'(takenIdx) != e) begin
            nFail++;
            $display("FAIL R10 actual=%0d expected=%0d", takenIdx, e);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nFail++;
      nChk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1;
    tick();
    // R1 reset state
    chk("R1 latch", latchRd, '0);
    chk("R1 mask", maskRd, '0);
    chk("R1 pend", pendRd, '0);
    chk("R1 gie", N'(gieOn), '0);

    // R9 privilege
    priv = 0; maskWr = 1; maskWrData = '1;
    tick();
    maskWr = 0;
    chk("R9 maskRd hidden", maskRd, '0);
    chk("R9 pendRd hidden", pendRd, '0);
    priv = 1; #1;
    chk("R9 mask unwritten", maskRd, '0);

    maskWr = 1; maskWrData = N'(32'h4);
    tick(); maskWr = 0;

    // R2 R3 R5 basic path on event 2
    expQ.push_back(2);
    evtIn[2] = 1;
    tick(2);
    chk("R2 latch set", latchRd, N'(32'h4));
    chk("R5 not yet pending", pendRd, '0);
    tick();
    chk("R5 pending after 3", pendRd, N'(32'h4));
    chk("R3 latch cleared", latchRd, '0);
    tick(2);
    chk("R2 level no relatch", latchRd, '0);

    // R4 queue next edge while pending
    evtIn[2] = 0; tick(3);
    evtIn[2] = 1; tick(3);
    chk("R4 queued latch", latchRd, N'(32'h4));
    chk("R4 still pending", pendRd, N'(32'h4));
    evtIn[2] = 0;

    // R8 retire, no accept in same cycle
    retStb = 1; expQ.push_back(2);
    tick(); retStb = 0;
    chk("R8 pend cleared", pendRd, '0);
    chk("R8 no accept during retire", latchRd, N'(32'h4));
    tick();
    chk("R8 requeued accepted", pendRd, N'(32'h4));
    retStb = 1; tick(); retStb = 0;
    chk("R8 empty", pendRd, '0);

    // R6 masked event held
    evtIn[3] = 1; tick(4); evtIn[3] = 0;
    chk("R6 masked latched", latchRd, N'(32'h8));
    chk("R6 masked not pending", pendRd, '0);

    // R7 latch write only on mask-clear bits
    latWr = 1; latWrData = N'(32'h204);
    tick(); latWr = 0;
    chk("R7 write result", latchRd, N'(32'h200));
    latWr = 1; latWrData = '0;
    tick(); latWr = 0;
    chk("R7 write clear", latchRd, '0);
    tick(2);

    // R10 R11 priority and nesting
    maskWr = 1; maskWrData = N'(32'h5F); tick(); maskWr = 0;
    expQ.push_back(4);
    evtIn[4] = 1; tick(3); evtIn[4] = 0;
    chk("R11 first pending", pendRd, N'(32'h10));
    expQ.push_back(1); expQ.push_back(3);
    evtIn[1] = 1; evtIn[3] = 1; tick(3);
    evtIn[1] = 0; evtIn[3] = 0;
    chk("R11 nested pend", pendRd, N'(32'h12));
    chk("R10 lower rank waits", latchRd, N'(32'h8));
    retStb = 1; tick(); retStb = 0;
    chk("R8 innermost retired", pendRd, N'(32'h10));
    tick();
    chk("R11 next nests", pendRd, N'(32'h18));
    retStb = 1; tick(2); retStb = 0;
    chk("R8 all retired", pendRd, '0);

    // R12 global enable gating
    evtIn[6] = 1; tick(4); evtIn[6] = 0;
    chk("R12 gated latched", latchRd, N'(32'h40));
    chk("R12 gated not pending", pendRd, '0);
    expQ.push_back(6);
    gieSet = 1; tick(); gieSet = 0;
    chk("R12 gie on", N'(gieOn), N'(1));
    tick();
    chk("R12 accepted", pendRd, N'(32'h40));
    gieSet = 1; gieClr = 1; tick(); gieSet = 0; gieClr = 0;
    chk("R12 clear wins", N'(gieOn), '0);
    retStb = 1; tick(); retStb = 0;
    tick(2);

    nChk++;
    if (expQ.size() != 0) begin
      nFail++;
      $display("FAIL R10 actual=%0d expected=0 leftover", expQ.size());
    end
    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule